// File: doc/BRIEF.md
# Compact Word-Addressed Processor Core

This block is a small multi-cycle processor for a 32-bit instruction set with sixteen general registers and word addressing. Instruction memory and data memory are private arrays inside the core. Every instruction takes two clock cycles. In the first cycle the word at the program counter is latched. In the second cycle the instruction is decoded from its 4-bit opcode and carried out: register writes, memory access and the program-counter update all happen in that cycle.

The instruction memory is filled through a load port, and only while reset is held low. After reset is released, the core runs from word 0 until it executes a halt. At that point it raises a halted flag and stops fetching. A combinational debug port reads any register at any time, so the results of a program can be checked.

Top module: `tiny_word_cpu`

## Requirements
- R1: While `rst_n` is low, every register reads zero and `halted` is low. A cycle with `load_en` high writes `load_data` into instruction word `load_addr`. After release, execution starts at word 0.
- R2: Encoding: opcode [31:28], X register [27:24], Y register [23:20], Z register [3:0], 20-bit offset [19:0], sign-extended wherever it is used. Opcodes: add=0, nand=1, addi=2. X receives Y+Z, ~(Y&Z) or Y+offset, respectively.
- R3: Load (opcode 3) writes X with the data word at Y+offset. Store (opcode 4) writes X into the data word at Y+offset. Negative offsets are allowed.
- R4: Opcode 5 sets PC to PC+1+offset when X equals Y, where PC is the address of the branch. Otherwise execution continues at PC+1.
- R5: Opcode 8 branches to PC+1+offset only when X is greater than Y as a signed two's-complement value. Backward offsets are allowed.
- R6: Opcode 6 writes PC+1 into Y, then jumps to the value X holds after that write. When X and Y are the same nonzero register, the jump goes to PC+1.
- R7: Opcode 9 writes PC+1+offset into X.
- R8: Register 0 always reads zero, and writes to it are dropped.
- R9: Opcode 7 raises `halted`, which stays high until reset. After it, no instruction executes and no register or data word changes.
- R10: Each instruction takes exactly two cycles. A program of N instructions that ends in a halt raises `halted` on the 2N-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Instruction-memory write strobe, honoured only during reset |
| load_addr | input | 6 | Instruction word address for loading |
| load_data | input | 32 | Instruction word to store |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| halted | output | 1 | High once a halt has executed |

## Verification
The assertions assume that `load_en` is raised only while reset is low. They also assume that programs stay inside the two memories and end with a halt. Every bench program is loaded during reset and ends in a halt within memory bounds. The bench steers every memory address into the sixteen data words it uses. An exhaustive sweep over pairs of signed edge values, including the most positive and most negative 20-bit immediates, checks the arithmetic and both compares. Separate programs cover jump-and-link aliasing, backward branches and relative addresses.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OFF_W  = 20;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_NAND = 4'd1;
    localparam logic [3:0] OP_ADDI = 4'd2;
    localparam logic [3:0] OP_LW   = 4'd3;
    localparam logic [3:0] OP_SW   = 4'd4;
    localparam logic [3:0] OP_BEQ  = 4'd5;
    localparam logic [3:0] OP_JALR = 4'd6;
    localparam logic [3:0] OP_HALT = 4'd7;
    localparam logic [3:0] OP_BGT  = 4'd8;
    localparam logic [3:0] OP_LEA  = 4'd9;

    typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_STOP} phase_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        phase_e          phase;
    } core_state_t;
endpackage

// File: rtl/twc_ram.sv
module twc_ram #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/twc_regfile.sv
module twc_regfile #(
    parameter int NREG = 16,
    parameter int W    = 32,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs_q[raddr[g]];
    end
endmodule

// File: rtl/twc_alu.sv
module twc_alu
    import twc_pkg::*;
(
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_y,
    input  logic [XLEN-1:0] src_z,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] cmp_x,
    input  logic [XLEN-1:0] cmp_y,
    output logic [XLEN-1:0] result,
    output logic            equal,
    output logic            greater
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = src_y + src_z;
            OP_NAND: result = ~(src_y & src_z);
            default: result = src_y + imm;
        endcase
    end

    assign equal   = (cmp_x == cmp_y);
    assign greater = ($signed(cmp_x) > $signed(cmp_y));
endmodule

// File: rtl/tiny_word_cpu.sv
module tiny_word_cpu
    import twc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IAW-1:0]    load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data,
    output logic              halted
);
    core_state_t st_q, st_d;

    // instruction fields
    logic [3:0]        op;
    logic [RIDX_W-1:0] rx, ry, rz;
    logic [XLEN-1:0]   off_sx;
    assign op     = st_q.ir[31:28];
    assign rx     = st_q.ir[27:24];
    assign ry     = st_q.ir[23:20];
    assign rz     = st_q.ir[RIDX_W-1:0];
    assign off_sx = {{(XLEN-OFF_W){st_q.ir[OFF_W-1]}}, st_q.ir[OFF_W-1:0]};

    // instruction memory
    logic [XLEN-1:0] imem_rd;
    twc_ram #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (load_en && !rst_n),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (st_q.pc[IAW-1:0]),
        .rdata (imem_rd)
    );

    // register file: X, Y, Z and debug read ports
    localparam int NRD = 4;
    logic [NRD-1:0][RIDX_W-1:0] rf_ra;
    logic [NRD-1:0][XLEN-1:0]   rf_rd;
    logic                       rf_we;
    logic [RIDX_W-1:0]          rf_wa;
    logic [XLEN-1:0]            rf_wd;
    assign rf_ra[0] = rx;
    assign rf_ra[1] = ry;
    assign rf_ra[2] = rz;
    assign rf_ra[3] = dbg_sel;

    twc_regfile #(.NREG(NREG), .W(XLEN), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_wa),
        .wdata (rf_wd),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );
    assign dbg_data = rf_rd[3];

    // datapath
    logic [XLEN-1:0] alu_res;
    logic            is_eq, is_gt;
    twc_alu u_alu (
        .op      (op),
        .src_y   (rf_rd[1]),
        .src_z   (rf_rd[2]),
        .imm     (off_sx),
        .cmp_x   (rf_rd[0]),
        .cmp_y   (rf_rd[1]),
        .result  (alu_res),
        .equal   (is_eq),
        .greater (is_gt)
    );

    // data memory
    logic            dm_we;
    logic [XLEN-1:0] dm_rd;
    twc_ram #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (alu_res[DAW-1:0]),
        .wdata (rf_rd[0]),
        .raddr (alu_res[DAW-1:0]),
        .rdata (dm_rd)
    );

    logic [XLEN-1:0] pc_inc, pc_rel;
    assign pc_inc = st_q.pc + 1'b1;
    assign pc_rel = pc_inc + off_sx;

    always_comb begin
        st_d  = st_q;
        rf_we = 1'b0;
        rf_wa = rx;
        rf_wd = alu_res;
        dm_we = 1'b0;
        unique case (st_q.phase)
            PH_FETCH: begin
                st_d.ir    = imem_rd;
                st_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                st_d.phase = PH_FETCH;
                st_d.pc    = pc_inc;
                case (op)
                    OP_ADD, OP_NAND, OP_ADDI: rf_we = 1'b1;
                    OP_LW: begin
                        rf_we = 1'b1;
                        rf_wd = dm_rd;
                    end
                    OP_SW:  dm_we = 1'b1;
                    OP_BEQ: if (is_eq) st_d.pc = pc_rel;
                    OP_BGT: if (is_gt) st_d.pc = pc_rel;
                    OP_JALR: begin
                        rf_we   = 1'b1;
                        rf_wa   = ry;
                        rf_wd   = pc_inc;
                        // the link write lands before the target is taken
                        st_d.pc = (rx == ry && ry != '0) ? pc_inc : rf_rd[0];
                    end
                    OP_LEA: begin
                        rf_we = 1'b1;
                        rf_wd = pc_rel;
                    end
                    OP_HALT: begin
                        st_d.phase = PH_STOP;
                        st_d.pc    = st_q.pc;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc    <= '0;
            st_q.ir    <= '0;
            st_q.phase <= PH_FETCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted = (st_q.phase == PH_STOP);

    // observation points for the checker
    logic [XLEN-1:0] pc_now;
    logic            in_exec;
    assign pc_now  = st_q.pc;
    assign in_exec = (st_q.phase == PH_EXEC);
endmodule

// File: rtl/twc_checker.sv
module twc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load_en,
    input logic        halted,
    input logic [31:0] pc,
    input logic        in_exec,
    input logic        rf_we,
    input logic        dm_we,
    input logic [3:0]  dbg_sel,
    input logic [31:0] dbg_data
);
    assert_load_only_in_reset_R1: assert property (@(posedge clk)
        load_en |-> !rst_n);

    assert_reset_clears_halt_R1: assert property (@(posedge clk)
        !rst_n |=> !halted);

    assert_zero_reg_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == 4'd0) |-> (dbg_data == 32'd0));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    assert_no_update_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rf_we && !dm_we));

    assert_exec_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec |=> !in_exec);

    assert_fetch_then_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_exec && !halted) |=> in_exec);
endmodule

bind tiny_word_cpu twc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .halted   (halted),
    .pc       (pc_now),
    .in_exec  (in_exec),
    .rf_we    (rf_we),
    .dm_we    (dm_we),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
);

// File: tb/tb_tiny_word_cpu.sv
`timescale 1ns/1ps
module tb_tiny_word_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [3:0]  dbg_sel = '0;
    logic [31:0] dbg_data;
    logic        halted;

    int total = 0;
    int bad = 0;
    logic [31:0] prog [16];
    int plen;
    int cyc;

    always #5 clk = ~clk;

    tiny_word_cpu dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted)
    );

    function automatic logic [31:0] enc(input logic [3:0] op, input int x, input int y, input int imm);
        logic [31:0] v = imm;
        return {op, x[3:0], y[3:0], v[19:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input int r, input logic [31:0] exp);
        @(negedge clk);
        dbg_sel = r[3:0];
        #1;
        check(req, dbg_data, exp);
    endtask

    // load prog during reset, release, count edges until halted
    task automatic run_prog(output int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < plen; i++) begin
            load_en = 1'b1;
            load_addr = i[5:0];
            load_data = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int av [7] = '{-524288, -2, -1, 0, 1, 2, 524287};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 halted in reset", {31'd0, halted}, 32'd0);

        // Program A: memory, lea, r0 write
        prog[0] = enc(4'd2, 1, 0, 5);          // addi r1 = 5
        prog[1] = enc(4'd2, 2, 0, -3);         // addi r2 = -3
        prog[2] = enc(4'd0, 3, 1, 2);          // add r3 = 2
        prog[3] = enc(4'd1, 4, 1, 2);          // nand r4
        prog[4] = enc(4'd2, 0, 0, 7);          // addi r0 (dropped)
        prog[5] = enc(4'd9, 5, 0, 3);          // lea r5 = 5+1+3 = 9
        prog[6] = enc(4'd4, 3, 1, 10);         // sw r3 -> word 15
        prog[7] = enc(4'd3, 6, 0, 15);         // lw r6 <- word 15
        prog[8] = enc(4'd3, 13, 2, 18);        // lw r13 <- word -3+18 = 15
        prog[9] = enc(4'd7, 0, 0, 0);          // halt
        plen = 10;
        run_prog(cyc);
        check("R9 halted raised", {31'd0, halted}, 32'd1);
        check_reg("R2 addi", 1, 32'd5);
        check_reg("R2 addi negative", 2, 32'hFFFF_FFFD);
        check_reg("R2 add", 3, 32'd2);
        check_reg("R2 nand", 4, 32'hFFFF_FFFA);
        check_reg("R8 r0 write dropped", 0, 32'd0);
        check_reg("R7 lea", 5, 32'd9);
        check_reg("R3 store then load", 6, 32'd2);
        check_reg("R3 negative base", 13, 32'd2);

        // R1: reset clears registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reg("R1 regs cleared", 5, 32'd0);
        check("R1 halted cleared", {31'd0, halted}, 32'd0);

        // Sweep: arithmetic and compares over signed edge values
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                int a = av[i];
                int b = av[j];
                prog[0] = enc(4'd2, 1, 0, a);
                prog[1] = enc(4'd2, 2, 0, b);
                prog[2] = enc(4'd0, 3, 1, 2);
                prog[3] = enc(4'd1, 4, 1, 2);
                prog[4] = enc(4'd5, 1, 2, 1);   // beq -> 6
                prog[5] = enc(4'd2, 7, 0, 1);
                prog[6] = enc(4'd8, 1, 2, 1);   // bgt -> 8
                prog[7] = enc(4'd2, 8, 0, 1);
                prog[8] = enc(4'd7, 0, 0, 0);
                plen = 9;
                run_prog(cyc);
                check_reg("R2 sweep add", 3, a + b);
                check_reg("R2 sweep nand", 4, ~(a & b));
                check_reg("R4 beq", 7, (a == b) ? 32'd0 : 32'd1);
                check_reg("R5 bgt signed", 8, (a > b) ? 32'd0 : 32'd1);
            end
        end

        // Program B: jalr and negative lea
        prog[0] = enc(4'd2, 1, 0, 5);
        prog[1] = enc(4'd6, 1, 2, 0);          // r2 = 2, pc = 5
        prog[2] = enc(4'd2, 9, 0, 1);
        prog[3] = enc(4'd7, 0, 0, 0);
        prog[4] = enc(4'd7, 0, 0, 0);
        prog[5] = enc(4'd6, 3, 3, 0);          // r3 = 6, pc = 6
        prog[6] = enc(4'd9, 12, 0, -7);        // r12 = 0
        prog[7] = enc(4'd2, 10, 0, 11);
        prog[8] = enc(4'd7, 0, 0, 0);
        prog[9] = enc(4'd2, 11, 0, 1);
        plen = 10;
        run_prog(cyc);
        check_reg("R6 link value", 2, 32'd2);
        check_reg("R6 jump skipped word", 9, 32'd0);
        check_reg("R6 same register link", 3, 32'd6);
        check_reg("R7 lea negative", 12, 32'd0);
        check_reg("R6 continues at pc+1", 10, 32'd11);
        check_reg("R9 nothing after halt", 11, 32'd0);

        // Program C: backward bgt loop, timing
        prog[0] = enc(4'd2, 1, 0, 3);
        prog[1] = enc(4'd2, 2, 2, 1);
        prog[2] = enc(4'd2, 1, 1, -1);
        prog[3] = enc(4'd8, 1, 0, -3);         // -> 1
        prog[4] = enc(4'd7, 0, 0, 0);
        plen = 5;
        run_prog(cyc);
        check("R10 cycles to halt", cyc, 32'd22);
        check_reg("R5 loop count", 2, 32'd3);
        check_reg("R5 loop exit", 1, 32'd0);
        repeat (10) @(negedge clk);
        check("R9 halted sticky", {31'd0, halted}, 32'd1);
        check_reg("R9 state frozen", 2, 32'd3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule